// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter with Owner Release

The block is the single point of arbitration for a bus shared by several masters. Every master presents its own request line to the block. A master may use the bus only after its bit of the one-hot grant vector goes high. Once a master has been granted, it owns the bus for as long as it needs, for example for a burst of many words. Ownership ends only when that master pulses its own release strobe. The block then clears the grant, leaves the bus idle for one cycle, and arbitrates again among the requests that are present at that moment.

Selection uses rotating priority. After each release, the master just after the departing owner ranks first, and the ranking wraps around past the last master. A waiting master is therefore passed over at most once by each of the other masters. A bus-busy output tells everyone that an owner holds the bus. The block contains no datapath and no address decoding.

Top module: `rr_bus_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant` is all zeros and `bus_busy` is 0. The first arbitration after reset ranks master 0 highest, so with every master requesting, master 0 wins.
- R2: At most one bit of `grant` is 1 in any cycle.
- R3: A grant bit only goes from 0 to 1 if that master's `req` bit was 1 in the previous cycle. With no requests, `grant` stays all zeros.
- R4: Once granted, a master keeps its grant, unchanged, until it pulses its own `rel_strobe` bit. This holds even if it drops its request in the meantime.
- R5: When the owner's `rel_strobe` bit is 1 at a clock edge, `grant` is all zeros and `bus_busy` is 0 in the following cycle. That cycle is one idle bus cycle.
- R6: When the bus is free, the winner is the first requesting master, searched from the priority pointer upward and wrapping from master N-1 to master 0. A release sets the pointer to the index just after the releasing owner, modulo N.
- R7: A `rel_strobe` bit from any master other than the current owner has no effect on `grant`, `bus_busy` or the pointer. This includes a strobe seen while the bus is idle.
- R8: A request raised while another master owns the bus and withdrawn before the bus is free leaves no trace. It neither wins nor moves the pointer.
- R9: `bus_busy` is 1 exactly in the cycles in which some bit of `grant` is 1.
- R10: If the bus is free and at least one `req` bit is 1 at a clock edge, a grant is visible in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | One request line per master |
| rel_strobe | input | N_MASTERS | One release pulse per master; only the owner's bit is obeyed |
| grant | output | N_MASTERS | One-hot (or zero) bus grant |
| bus_busy | output | 1 | High while an owner holds the bus |

## Verification
The bench first goes after the wrap of the rotating pointer. A design that kept fixed priority, or that advanced the pointer from the winner rather than the releasing owner, would hand the bus to the wrong master after a release by master N-1 or by a middle master. It then checks that a grant survives its owner dropping the request, and that the bus survives release strobes from non-owners. A design that recomputed the grant every cycle or obeyed any strobe would drop or steal the bus mid-burst. The bench also withdraws a request while the bus is owned, which catches a design that latches pending requests. Finally, it checks the single idle cycle after a release, where a design without it would show two owners back to back with no gap or would insert extra idle cycles.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_e;

    // Width of an index into a set of n masters (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb_rr_select.sv
module arb_rr_select
    import rr_arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 4,
    localparam int unsigned IW = idx_width(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IW-1:0]        ptr,
    output logic [IW-1:0]        win_idx,
    output logic                 win_vld
);

    // Scan from ptr upward with wrap; the first requester found wins.
    always_comb begin
        int          cand;
        logic [IW-1:0] cidx;
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = 0; k < int'(N_MASTERS); k++) begin
            cand = int'(ptr) + k;
            if (cand >= int'(N_MASTERS)) begin
                cand = cand - int'(N_MASTERS);
            end
            cidx = IW'(cand);
            if (!win_vld && req[cidx]) begin
                win_vld = 1'b1;
                win_idx = cidx;
            end
        end
    end

endmodule

// File: rtl/arb_ptr_reg.sv
module arb_ptr_reg
    import rr_arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 4,
    localparam int unsigned IW = idx_width(N_MASTERS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [IW-1:0] last_owner,
    output logic [IW-1:0] ptr
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_MASTERS - 1);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_next;

    always_comb begin
        ptr_next = ptr_q;
        if (advance) begin
            ptr_next = (last_owner == LAST_IDX) ? '0 : last_owner + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_next;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/arb_owner_ctrl.sv
module arb_owner_ctrl
    import rr_arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 4,
    localparam int unsigned IW = idx_width(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_vld,
    input  logic [IW-1:0]        win_idx,
    input  logic [N_MASTERS-1:0] rel_strobe,
    output logic [N_MASTERS-1:0] grant,
    output logic                 bus_busy,
    output logic                 release_evt,
    output logic [IW-1:0]        owner_idx
);

    bus_state_e    state_q, state_next;
    logic [IW-1:0] owner_q, owner_next;
    logic          busy_q;
    logic          held;

    assign held        = (state_q == BUS_HELD);
    assign release_evt = held && rel_strobe[owner_q];

    always_comb begin
        state_next = state_q;
        owner_next = owner_q;
        unique case (state_q)
            BUS_FREE: begin
                if (win_vld) begin
                    state_next = BUS_HELD;
                    owner_next = win_idx;
                end
            end
            BUS_HELD: begin
                if (release_evt) begin
                    state_next = BUS_FREE;
                end
            end
            default: state_next = BUS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_FREE;
            owner_q <= '0;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_next;
            owner_q <= owner_next;
            if (!held && win_vld) begin
                busy_q <= 1'b1;
            end else if (release_evt) begin
                busy_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < int'(N_MASTERS); g++) begin : g_grant
        assign grant[g] = held && (owner_q == IW'(g));
    end

    assign bus_busy  = busy_q;
    assign owner_idx = owner_q;

endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
    import rr_arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic [N_MASTERS-1:0] rel_strobe,
    output logic [N_MASTERS-1:0] grant,
    output logic                 bus_busy
);

    localparam int unsigned IW = idx_width(N_MASTERS);

    logic [IW-1:0] ptr;
    logic [IW-1:0] win_idx;
    logic          win_vld;
    logic          release_evt;
    logic [IW-1:0] owner_idx;

    arb_rr_select #(.N_MASTERS(N_MASTERS)) u_select (
        .req     (req),
        .ptr     (ptr),
        .win_idx (win_idx),
        .win_vld (win_vld)
    );

    arb_owner_ctrl #(.N_MASTERS(N_MASTERS)) u_owner (
        .clk         (clk),
        .rst         (rst),
        .win_vld     (win_vld),
        .win_idx     (win_idx),
        .rel_strobe  (rel_strobe),
        .grant       (grant),
        .bus_busy    (bus_busy),
        .release_evt (release_evt),
        .owner_idx   (owner_idx)
    );

    arb_ptr_reg #(.N_MASTERS(N_MASTERS)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .advance    (release_evt),
        .last_owner (owner_idx),
        .ptr        (ptr)
    );

endmodule

// File: rtl/rr_bus_arbiter_chk.sv
module rr_bus_arbiter_chk #(
    parameter int unsigned N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req,
    input logic [N_MASTERS-1:0] rel_strobe,
    input logic [N_MASTERS-1:0] grant,
    input logic                 bus_busy
);

    // R2: never more than one owner
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3: a grant bit only rises for a master that was requesting
    for (genvar g = 0; g < int'(N_MASTERS); g++) begin : g_rise
        a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
            $rose(grant[g]) |-> $past(req[g]));
    end

    // R4 and R7: without a release by the owner, the grant stays as it is
    a_r4_hold_until_release: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && ((grant & rel_strobe) == '0)) |=> $stable(grant));

    // R5: owner release gives one idle cycle
    a_r5_idle_after_release: assert property (@(posedge clk) disable iff (rst)
        ((grant & rel_strobe) != '0) |=> ((grant == '0) && !bus_busy));

    // R9: busy flag tracks ownership
    a_r9_busy_matches_grant: assert property (@(posedge clk) disable iff (rst)
        bus_busy == (grant != '0));

    // R10: a free bus with a request is granted next cycle
    a_r10_grant_latency: assert property (@(posedge clk) disable iff (rst)
        ((grant == '0) && (req != '0)) |=> (grant != '0));

endmodule

bind rr_bus_arbiter rr_bus_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .rel_strobe (rel_strobe),
    .grant      (grant),
    .bus_busy   (bus_busy)
);

// File: tb/rr_bus_arbiter_tb_top.sv
module rr_bus_arbiter_tb_top;

    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NM-1:0] req = '0;
    logic [NM-1:0] rel_strobe = '0;
    logic [NM-1:0] grant;
    logic          bus_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rr_bus_arbiter #(.N_MASTERS(NM)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .rel_strobe (rel_strobe),
        .grant      (grant),
        .bus_busy   (bus_busy)
    );

    // Behavioural reference: owner index (-1 = free) and rotating pointer
    int m_owner = -1;
    int m_ptr   = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_owner = -1;
            m_ptr   = 0;
        end else if (m_owner >= 0) begin
            if (rel_strobe[m_owner]) begin
                m_ptr   = (m_owner + 1) % NM;
                m_owner = -1;
            end
        end else begin
            for (int k = 0; k < NM; k++) begin
                if (m_owner < 0 && req[(m_ptr + k) % NM]) begin
                    m_owner = (m_ptr + k) % NM;
                end
            end
        end
    end

    function automatic logic [NM-1:0] model_grant();
        logic [NM-1:0] v;
        v = '0;
        if (m_owner >= 0) v[m_owner] = 1'b1;
        return v;
    endfunction

    // Per-cycle comparison against the reference (R2, R4, R6, R9)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (grant !== model_grant() || bus_busy !== (m_owner >= 0)) begin
                errors++;
                $display("FAIL R2/R4/R6/R9 model: grant=%b busy=%b expected grant=%b busy=%b",
                         grant, bus_busy, model_grant(), (m_owner >= 0));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_g(string tag, logic [NM-1:0] exp);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected %b", tag, grant, exp);
        end
    endtask

    task automatic chk_b(string tag, logic exp);
        checks++;
        if (bus_busy !== exp) begin
            errors++;
            $display("FAIL %s: bus_busy=%b expected %b", tag, bus_busy, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt [NM];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_g("R1 reset grant", 4'b0000);
        chk_b("R1 reset busy", 1'b0);

        req = 4'b1111; tick();
        chk_g("R1 pointer at master 0 / R10", 4'b0001);
        chk_b("R9 busy while owned", 1'b1);

        req = 4'b1110; tick(); tick(); tick();
        chk_g("R4 hold after request drop", 4'b0001);

        rel_strobe = 4'b0100; tick(); rel_strobe = '0;
        chk_g("R7 foreign release ignored", 4'b0001);

        rel_strobe = 4'b0001; tick(); rel_strobe = '0;
        chk_g("R5 idle cycle grant", 4'b0000);
        chk_b("R5 idle cycle busy", 1'b0);
        tick();
        chk_g("R6 next after master 0", 4'b0010);

        req = 4'b0001; rel_strobe = 4'b0010; tick(); rel_strobe = '0;
        chk_g("R5 idle after master 1", 4'b0000);
        tick();
        chk_g("R6 wrap to master 0", 4'b0001);

        req = 4'b0011; tick();
        req = 4'b0001; tick();
        chk_g("R8 owner kept during withdrawn request", 4'b0001);
        req = 4'b0100; rel_strobe = 4'b0001; tick(); rel_strobe = '0;
        tick();
        chk_g("R8 withdrawn request left no trace", 4'b0100);

        req = 4'b1010; rel_strobe = 4'b0100; tick(); rel_strobe = '0;
        tick();
        chk_g("R6 pointer after master 2", 4'b1000);

        req = '0; rel_strobe = 4'b1000; tick(); rel_strobe = '0;
        rel_strobe = 4'b0110; tick(); rel_strobe = '0;
        tick(); tick();
        chk_g("R3 no request no grant", 4'b0000);
        chk_b("R7 idle strobes ignored", 1'b0);

        // Random traffic: bursts of random length, withdrawals, stray strobes
        for (int i = 0; i < NM; i++) cnt[i] = 0;
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NM; i++) begin
                if (grant[i]) begin
                    if (cnt[i] == 0) begin
                        rel_strobe[i] = 1'b1;
                        req[i] = 1'b0;
                    end else begin
                        cnt[i]--;
                        rel_strobe[i] = 1'b0;
                        if ($urandom % 4 == 0) req[i] = 1'b0;
                    end
                end else begin
                    rel_strobe[i] = ($urandom % 12 == 0);
                    if (req[i]) begin
                        if ($urandom % 10 == 0) req[i] = 1'b0;
                    end else if ($urandom % 4 == 0) begin
                        req[i] = 1'b1;
                        cnt[i] = $urandom % 6;
                    end
                end
            end
            tick();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule